// File: doc/BRIEF.md
# Multiplexed Bus Cycle Sequencer

This block turns one request from an execution core into the T-state sequence of an 8-bit processor's external bus. The bus is multiplexed: the low address byte and the data byte share one set of pins. The core gives a cycle kind, a 16-bit address and, for stores, a write byte. The sequencer then drives the high address byte, the shared bus with its output enable, the latch strobe `ale`, the active-low strobes `rd_n` and `wr_n`, the `io_m` space select and the two status bits. When the cycle ends it returns the read byte and a one-clock `done` pulse.

The cycle kinds are coded on `req_kind` as follows: 0 opcode fetch, 1 memory read, 2 memory write, 3 I/O read, 4 I/O write, 5 halt. Codes 6 and 7 are not used. A request is taken only when `req_valid` is high in a clock where the sequencer is idle. The T-state labels below count the clocks that follow the accepting edge: T1 is the first of them. The `ready` input stretches the strobed part of a transfer with wait states.

Top module: `mux_bus_seq`

## Requirements
- R1: After reset the outputs are idle: `rd_n`=1, `wr_n`=1, `ale`=0, `ad_oe`=0, `done`=0, `{s1,s0}`=00, `rdata`=0.
- R2: `ale` is high during T1 only. In T1 `ad_oe`=1, `ad_out` carries address bits [7:0] and `addr_hi` carries bits [15:8]. `addr_hi` holds bits [15:8] for every T-state of the cycle.
- R3: An opcode fetch (kind 0) drives `{s1,s0}`=11 and `io_m`=0 and lasts 4 T-states. `rd_n` is low in T2 and T3 and high in T4.
- R4: An opcode fetch with `req_long`=1 lasts 6 T-states. `rd_n` is high in T4 through T6 and `ad_oe` is 0 there.
- R5: A read (kind 1 or 3) lasts 3 T-states and drives `{s1,s0}`=10. `rd_n` is low from T2 through T3. `rdata` takes the value of `ad_in` at the clock edge that ends T3, and a fetch captures it the same way.
- R6: A write (kind 2 or 4) lasts 3 T-states and drives `{s1,s0}`=01. `wr_n` is low from T2 through T3, and over that span `ad_oe`=1 and `ad_out` carries the write byte.
- R7: `io_m` is 1 for kinds 3 and 4 and 0 for kinds 0, 1 and 2.
- R8: If `ready` is low at the edge that ends T2, or at the edge that ends a wait state, a wait state follows. The strobe and the bus stay as they were in T2, and T3 follows the first edge at which `ready` is high.
- R9: `done` is high for exactly one clock, the clock right after the last T-state. `req_valid` is ignored while a cycle is in progress, and a request with kind 6 or 7 starts no cycle.
- R10: A halt (kind 5) drives `{s1,s0}`=00 with `rd_n`=`wr_n`=1, `ale`=0 and `ad_oe`=0. The sequencer then stays in that state, ignoring all requests and giving no `done`, until reset.
- R11: `rd_n` and `wr_n` are never low together, and `ad_oe` is 0 whenever `rd_n` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; each cycle is one T-state |
| rst_n | input | 1 | Asynchronous reset, active low |
| req_valid | input | 1 | Request strobe from the core |
| req_kind | input | 3 | Cycle kind code |
| req_long | input | 1 | Stretch an opcode fetch to 6 T-states |
| req_addr | input | 16 | Cycle address |
| req_wdata | input | 8 | Byte to write |
| ready | input | 1 | Low inserts wait states |
| ad_in | input | 8 | Value sensed on the shared bus |
| addr_hi | output | 8 | Address bits [15:8] |
| ad_out | output | 8 | Value driven on the shared bus |
| ad_oe | output | 1 | Output enable for the shared bus |
| ale | output | 1 | Address latch strobe |
| rd_n | output | 1 | Read strobe, active low |
| wr_n | output | 1 | Write strobe, active low |
| io_m | output | 1 | 1 for I/O space, 0 for memory |
| s1 | output | 1 | Status bit 1 |
| s0 | output | 1 | Status bit 0 |
| rdata | output | 8 | Byte captured by the last read or fetch |
| done | output | 1 | One-clock completion pulse |

## Verification
The condition hardest to reach from the ports is a request arriving while a cycle is already under way. A bus master that behaves well never does this. The stimulus therefore pulses `req_valid` with a write kind for one clock in the middle of a cycle. It then checks that no extra cycle follows: `ale` stays low and no second `done` pulse appears. The bench also sweeps every kind against zero, one and two wait states and both fetch lengths. For each of these it predicts the strobe, `ale` and bus values for every clock from the sweep indices.

// File: rtl/bus_seq_pkg.sv
package bus_seq_pkg;

  typedef enum logic [2:0] {
    K_FETCH = 3'd0,
    K_MRD   = 3'd1,
    K_MWR   = 3'd2,
    K_IORD  = 3'd3,
    K_IOWR  = 3'd4,
    K_HALT  = 3'd5
  } kind_e;

  typedef enum logic [3:0] {
    TS_IDLE, TS_T1, TS_T2, TS_TW, TS_T3, TS_T4, TS_T5, TS_T6, TS_HALT
  } tstate_e;

  function automatic logic kind_ok(input logic [2:0] k);
    return k <= 3'd5;
  endfunction

  function automatic logic kind_reads(input kind_e k);
    return (k == K_FETCH) || (k == K_MRD) || (k == K_IORD);
  endfunction

  function automatic logic kind_io(input kind_e k);
    return (k == K_IORD) || (k == K_IOWR);
  endfunction

  // {s1,s0}: fetch 11, read 10, write 01, halt 00
  function automatic logic [1:0] kind_status(input kind_e k);
    case (k)
      K_FETCH:        return 2'b11;
      K_MRD, K_IORD:  return 2'b10;
      K_MWR, K_IOWR:  return 2'b01;
      default:        return 2'b00;
    endcase
  endfunction

endpackage

// File: rtl/bus_seq_ctl.sv
module bus_seq_ctl
  import bus_seq_pkg::*;
#(
  parameter int ADDR_W = 16,
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  input  logic [2:0]        req_kind,
  input  logic              req_long,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [DATA_W-1:0] req_wdata,
  input  logic              ready,
  input  logic [DATA_W-1:0] ad_in,
  output tstate_e           tstate,
  output kind_e             kind_q,
  output logic [ADDR_W-1:0] addr_q,
  output logic [DATA_W-1:0] wdata_q,
  output logic [DATA_W-1:0] rdata,
  output logic              done
);

  logic    long_q;
  tstate_e ts_next;
  logic    accept;
  logic    last_ts;
  logic    in_strobe_phase;

  assign accept          = (tstate == TS_IDLE) && req_valid && kind_ok(req_kind);
  assign in_strobe_phase = (tstate == TS_T2) || (tstate == TS_TW);

  always_comb begin
    ts_next = tstate;
    last_ts = 1'b0;
    case (tstate)
      TS_IDLE: if (accept) ts_next = (kind_e'(req_kind) == K_HALT) ? TS_HALT : TS_T1;
      TS_T1:   ts_next = TS_T2;
      TS_T2,
      TS_TW:   ts_next = ready ? TS_T3 : TS_TW;
      TS_T3:   if (kind_q == K_FETCH) ts_next = TS_T4;
               else begin ts_next = TS_IDLE; last_ts = 1'b1; end
      TS_T4:   if (long_q) ts_next = TS_T5;
               else begin ts_next = TS_IDLE; last_ts = 1'b1; end
      TS_T5:   ts_next = TS_T6;
      TS_T6:   begin ts_next = TS_IDLE; last_ts = 1'b1; end
      TS_HALT: ts_next = TS_HALT;
      default: ts_next = TS_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tstate  <= TS_IDLE;
      kind_q  <= K_FETCH;
      long_q  <= 1'b0;
      addr_q  <= '0;
      wdata_q <= '0;
      rdata   <= '0;
      done    <= 1'b0;
    end else begin
      tstate <= ts_next;
      done   <= last_ts;
      if (accept) begin
        kind_q  <= kind_e'(req_kind);
        long_q  <= req_long;
        addr_q  <= req_addr;
        wdata_q <= req_wdata;
      end
      if (tstate == TS_T3 && kind_reads(kind_q))
        rdata <= ad_in;
    end
  end

  assert_done_pulse_R9: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);
  assert_busy_ignores_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (tstate != TS_IDLE && tstate != TS_HALT && tstate != TS_T6 && tstate != TS_T3 && tstate != TS_T4)
      |=> (tstate != TS_IDLE));
  assert_halt_sticky_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (tstate == TS_HALT) |=> (tstate == TS_HALT) && !done);
  assert_wait_insert_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (in_strobe_phase && !ready) |=> (tstate == TS_TW));
  assert_wait_exit_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (in_strobe_phase && ready) |=> (tstate == TS_T3));

endmodule

// File: rtl/bus_seq_drive.sv
module bus_seq_drive
  import bus_seq_pkg::*;
#(
  parameter int ADDR_W = 16,
  parameter int DATA_W = 8
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  tstate_e                  tstate,
  input  kind_e                    kind_q,
  input  logic [ADDR_W-1:0]        addr_q,
  input  logic [DATA_W-1:0]        wdata_q,
  output logic [ADDR_W-DATA_W-1:0] addr_hi,
  output logic [DATA_W-1:0]        ad_out,
  output logic                     ad_oe,
  output logic                     ale,
  output logic                     rd_n,
  output logic                     wr_n,
  output logic                     io_m,
  output logic [1:0]               status
);

  localparam int HI_W = ADDR_W - DATA_W;

  logic active;
  logic xfer;
  logic is_rd;

  assign active = (tstate != TS_IDLE) && (tstate != TS_HALT);
  assign xfer   = (tstate == TS_T2) || (tstate == TS_TW) || (tstate == TS_T3);
  assign is_rd  = kind_reads(kind_q);

  always_comb begin
    addr_hi = active ? addr_q[ADDR_W-1:DATA_W] : {HI_W{1'b0}};
    ale     = (tstate == TS_T1);
    rd_n    = !(xfer && is_rd);
    wr_n    = !(xfer && !is_rd);
    ad_oe   = (tstate == TS_T1) || (xfer && !is_rd);
    ad_out  = (tstate == TS_T1) ? addr_q[DATA_W-1:0] : (ad_oe ? wdata_q : '0);
    io_m    = active && kind_io(kind_q);
    status  = active ? kind_status(kind_q) : 2'b00;
  end

  assert_strobe_excl_R11: assert property (@(posedge clk) disable iff (!rst_n)
    !(!rd_n && !wr_n));
  assert_bus_release_R11: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_n |-> !ad_oe);
  assert_ale_single_R2: assert property (@(posedge clk) disable iff (!rst_n)
    ale |=> !ale);
  assert_addr_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (active && $past(active) && !ale) |-> $stable(addr_hi));

endmodule

// File: rtl/mux_bus_seq.sv
module mux_bus_seq
  import bus_seq_pkg::*;
#(
  parameter int ADDR_W = 16,
  parameter int DATA_W = 8
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     req_valid,
  input  logic [2:0]               req_kind,
  input  logic                     req_long,
  input  logic [ADDR_W-1:0]        req_addr,
  input  logic [DATA_W-1:0]        req_wdata,
  input  logic                     ready,
  input  logic [DATA_W-1:0]        ad_in,
  output logic [ADDR_W-DATA_W-1:0] addr_hi,
  output logic [DATA_W-1:0]        ad_out,
  output logic                     ad_oe,
  output logic                     ale,
  output logic                     rd_n,
  output logic                     wr_n,
  output logic                     io_m,
  output logic                     s1,
  output logic                     s0,
  output logic [DATA_W-1:0]        rdata,
  output logic                     done
);

  tstate_e           tstate;
  kind_e             kind_q;
  logic [ADDR_W-1:0] addr_q;
  logic [DATA_W-1:0] wdata_q;
  logic [1:0]        status;

  bus_seq_ctl #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_ctl (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_kind(req_kind),
    .req_long(req_long), .req_addr(req_addr), .req_wdata(req_wdata),
    .ready(ready), .ad_in(ad_in), .tstate(tstate), .kind_q(kind_q),
    .addr_q(addr_q), .wdata_q(wdata_q), .rdata(rdata), .done(done)
  );

  bus_seq_drive #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_drv (
    .clk(clk), .rst_n(rst_n), .tstate(tstate), .kind_q(kind_q),
    .addr_q(addr_q), .wdata_q(wdata_q), .addr_hi(addr_hi), .ad_out(ad_out),
    .ad_oe(ad_oe), .ale(ale), .rd_n(rd_n), .wr_n(wr_n), .io_m(io_m),
    .status(status)
  );

  assign s1 = status[1];
  assign s0 = status[0];

  assert_fetch_status_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (ale && !io_m && s1 && s0) |=> (s1 && s0));
  assert_halt_quiet_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (tstate == TS_HALT) |-> (rd_n && wr_n && !ale && !ad_oe && !s1 && !s0));

endmodule

// File: tb/sim_mux_bus_seq.sv
module sim_mux_bus_seq;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       req_valid = 1'b0;
  logic [2:0] req_kind = 3'd0;
  logic       req_long = 1'b0;
  logic [15:0] req_addr = 16'h0;
  logic [7:0] req_wdata = 8'h0;
  logic       ready = 1'b1;
  logic [7:0] ad_in = 8'h0;
  logic [7:0] addr_hi, ad_out, rdata;
  logic       ad_oe, ale, rd_n, wr_n, io_m, s1, s0, done;

  int checks = 0;
  int errors = 0;
  int cyc = 0;

  always #2.5 clk = ~clk;

  mux_bus_seq u0 (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_kind(req_kind),
    .req_long(req_long), .req_addr(req_addr), .req_wdata(req_wdata),
    .ready(ready), .ad_in(ad_in), .addr_hi(addr_hi), .ad_out(ad_out),
    .ad_oe(ad_oe), .ale(ale), .rd_n(rd_n), .wr_n(wr_n), .io_m(io_m),
    .s1(s1), .s0(s0), .rdata(rdata), .done(done)
  );

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  task automatic finish_run();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > 100000) begin
      checks++; errors++;
      $display("FAIL watchdog: actual %0d expected < 100000", cyc);
      finish_run();
    end
  end

  // One full bus cycle; waits = wait states; poke = inject a request mid-cycle
  task automatic run_cycle(input int kind, input bit lng, input int waits, input bit poke);
    logic [15:0] a;
    logic [7:0]  wd, rv;
    bit          rd_kind, io_kind, fetch;
    int          base, len;
    logic [1:0]  st;
    a  = 16'h1000 * kind[15:0] + 16'h0111 * waits[15:0] + (lng ? 16'h8000 : 16'h0) + 16'h00A5;
    wd = 8'h3C ^ (kind[7:0] * 8'd17 + waits[7:0]);
    rv = 8'hC3 + kind[7:0] * 8'd7 + waits[7:0];
    fetch   = (kind == 0);
    rd_kind = (kind == 0) || (kind == 1) || (kind == 3);
    io_kind = (kind == 3) || (kind == 4);
    base = fetch ? (lng ? 6 : 4) : 3;
    len  = base + waits;
    st   = fetch ? 2'b11 : (rd_kind ? 2'b10 : 2'b01);

    @(negedge clk);
    req_valid = 1'b1; req_kind = kind[2:0]; req_long = lng;
    req_addr = a; req_wdata = wd; ad_in = rv; ready = 1'b1;
    for (int k = 1; k <= len + 1; k++) begin
      @(negedge clk);
      if (k == 1) begin
        req_valid = 1'b0;
        chk(ale && ad_oe && ad_out == a[7:0], "R2", "T1 ale/oe/low addr",
            {ale, ad_oe, ad_out}, {2'b11, a[7:0]});
      end else if (k <= len) begin
        chk(!ale, "R2", "ale outside T1", ale, 0);
      end
      if (k <= len) begin
        bit strobe;
        strobe = (k >= 2) && (k <= waits + 3);
        chk(addr_hi == a[15:8], "R2", "addr_hi held", addr_hi, a[15:8]);
        chk({s1, s0} == st, fetch ? "R3" : (rd_kind ? "R5" : "R6"), "status", {s1, s0}, st);
        chk(io_m == io_kind, "R7", "io_m", io_m, io_kind);
        chk(rd_n == !(strobe && rd_kind), waits > 0 ? "R8" : (fetch ? (lng ? "R4" : "R3") : "R5"),
            "rd_n", rd_n, !(strobe && rd_kind));
        chk(wr_n == !(strobe && !rd_kind), waits > 0 ? "R8" : "R6", "wr_n", wr_n, !(strobe && !rd_kind));
        if (k > 1) begin
          bit oe_exp;
          oe_exp = strobe && !rd_kind;
          chk(ad_oe == oe_exp, rd_kind ? "R11" : "R6", "ad_oe", ad_oe, oe_exp);
          if (oe_exp) chk(ad_out == wd, "R6", "write byte", ad_out, wd);
        end
        chk(!done, "R9", "done early", done, 0);
      end else begin
        chk(done, fetch ? (lng ? "R4" : "R3") : "R9", "done after last T", done, 1);
        if (rd_kind) chk(rdata == rv, "R5", "rdata", rdata, rv);
      end
      if (poke && k == 2) begin
        req_valid = 1'b1; req_kind = 3'd2;
      end
      if (poke && k == 3) req_valid = 1'b0;
      if (k >= 2) ready = !(k <= waits + 1);
    end
    ready = 1'b1;
    @(negedge clk);
    chk(!done && !ale, "R9", "done single pulse / no new cycle", {done, ale}, 0);
    @(negedge clk);
    chk(!ale && rd_n && wr_n, "R9", "stays idle", {ale, rd_n, wr_n}, 3'b011);
  endtask

  initial begin
    #12;
    chk(rd_n && wr_n && !ale && !ad_oe && !done && {s1, s0} == 2'b00 && rdata == 8'h00,
        "R1", "reset state", {rd_n, wr_n, ale, ad_oe, done, s1, s0}, 7'b1100000);
    rst_n = 1'b1;
    @(negedge clk);
    chk(rd_n && wr_n && !ale && !done, "R1", "idle after reset", {rd_n, wr_n, ale, done}, 4'b1100);

    for (int kd = 0; kd <= 4; kd++)
      for (int w = 0; w <= 2; w++) begin
        run_cycle(kd, 1'b0, w, 1'b0);
        if (kd == 0) run_cycle(kd, 1'b1, w, 1'b0);
      end
    run_cycle(1, 1'b0, 1, 1'b1);
    run_cycle(0, 1'b1, 0, 1'b1);

    // unused kind codes
    for (int kc = 6; kc <= 7; kc++) begin
      @(negedge clk);
      req_valid = 1'b1; req_kind = kc[2:0];
      @(negedge clk);
      req_valid = 1'b0;
      for (int j = 0; j < 3; j++) begin
        chk(!ale && rd_n && wr_n && !done, "R9", "unused kind starts nothing",
            {ale, rd_n, wr_n, done}, 4'b0110);
        @(negedge clk);
      end
    end

    // halt
    req_valid = 1'b1; req_kind = 3'd5;
    @(negedge clk);
    req_valid = 1'b0;
    for (int j = 0; j < 6; j++) begin
      if (j == 2) begin req_valid = 1'b1; req_kind = 3'd1; end
      chk({s1, s0} == 2'b00 && rd_n && wr_n && !ale && !ad_oe && !done, "R10", "halted bus",
          {s1, s0, rd_n, wr_n, ale, ad_oe, done}, 7'b0011000);
      @(negedge clk);
    end
    req_valid = 1'b0;
    rst_n = 1'b0;
    @(negedge clk);
    rst_n = 1'b1;
    run_cycle(2, 1'b0, 0, 1'b0);
    finish_run();
  end

endmodule